// File: doc/BRIEF.md
# Triggered Stream Capture Buffer

This block records a fixed number of samples from one streaming input into an on-chip RAM. A host then reads the samples back over a simple memory-mapped read port. Only cycles in which the stream's valid input is high deliver a sample. Once the configured number of samples has been written, the RAM holds them until a new capture begins. A small register bank, with its own read and write port, shows a live sync-pulse count, the number of words written so far, and the number of valid cycles since the last sync pulse. The same bank holds a programmable delay, an arm strobe and a constant version word.

What starts a capture depends on one elaboration-time option and on the delay register. When sync use is disabled, the block captures freely: the first samples after reset are kept, and a new capture begins only after the host reads the last sample address. When sync use is enabled and the delay is zero, every sync pulse restarts the capture at address 0 and overwrites the previous contents. When sync use is enabled and the delay is non-zero, the block captures once per arm. The host arms the block, the next sync pulse starts a countdown over valid cycles, and the capture follows that countdown.

Top module: `stream_capture_buffer`

## Requirements
- R1: Only input cycles with `s_valid` high are written. Capture stops after NUM_SAMPLES words, so the word count never exceeds NUM_SAMPLES.
- R2: With USE_SYNC=0, the first NUM_SAMPLES valid words after reset are captured. Later input is ignored until the host reads RAM address NUM_SAMPLES-1 while the capture is complete. The valid words that follow that read are then captured from address 0.
- R3: With USE_SYNC=1 and a delay of 0, every sync pulse restarts the capture at address 0 and overwrites the old contents. A valid sample in the sync cycle itself is stored as word 0.
- R4: With USE_SYNC=1 and a delay D>0, a register write to offset 2 (any data) arms the block. The next sync pulse starts a countdown that skips D valid cycles, counting the sync cycle if it is valid. The following NUM_SAMPLES valid words are then stored at addresses 0 upward.
- R5: After an armed capture (D>0) completes, further sync pulses write nothing until the block is armed again.
- R6: In armed mode, a sync pulse during the countdown or the capture does not restart it. It is still counted at offset 0.
- R7: Offset 0 reads a 32-bit count of sync pulses. It clears when the host reads RAM address NUM_SAMPLES-1 and does not clear on reads of other addresses.
- R8: Offset 1 reads the number of words written in the current capture. It returns to 0 when a new capture begins.
- R9: Offset 2 reads the number of valid cycles since the latest sync pulse, counting the sync cycle if it is valid. A sync pulse restarts the count.
- R10: Offset 3 is a read/write delay register. Offset 7 reads the VERSION parameter. Offsets 4 to 6 read 0. Writes to offsets 0, 1 and 4 to 7 change nothing.
- R11: RAM reads and register reads return data one cycle after the request, together with a one-cycle valid strobe. RAM address k holds capture word k.
- R12: After reset, the sync count, word count, valid count and delay all read 0, and neither read-valid strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream sample valid |
| s_data | input | DATA_W | Stream sample |
| s_sync | input | 1 | Stream sync pulse |
| ram_rd_en | input | 1 | RAM read request |
| ram_rd_addr | input | ADDR_W | RAM word address |
| ram_rd_data | output | DATA_W | RAM read data |
| ram_rd_valid | output | 1 | RAM read data valid |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read request |
| reg_addr | input | 3 | Register word offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read data |
| reg_rd_valid | output | 1 | Register read data valid |

## Verification
The capture path is tested with several valid masks. A solid mask checks that capture stops at the configured count. An alternating mask shows whether invalid cycles are skipped or stored. A mask with gaps, combined with non-zero delays, separates a countdown over valid cycles from a countdown over clock cycles, and shows whether the sync cycle's own sample is counted. A second sync pulse placed inside the countdown produces a different RAM image if it were wrongly taken as a new trigger. Repeated sync pulses with no new arm show whether the armed capture is one-shot. A second instance built without sync use is checked for a hold until the last-address read, and for a clean refill afterwards.

// File: rtl/cap_buf_pkg.sv
package cap_buf_pkg;
   typedef enum logic [1:0] {
      PH_IDLE,
      PH_SKIP,
      PH_FILL,
      PH_DONE
   } cap_phase_t;

   localparam int REG_W  = 32;
   localparam int REG_AW = 3;

   localparam logic [REG_AW-1:0] OFS_SYNCS   = 3'd0;
   localparam logic [REG_AW-1:0] OFS_WORDS   = 3'd1;
   localparam logic [REG_AW-1:0] OFS_VALIDS  = 3'd2;
   localparam logic [REG_AW-1:0] OFS_DELAY   = 3'd3;
   localparam logic [REG_AW-1:0] OFS_VERSION = 3'd7;
endpackage

// File: rtl/cap_ram.sv
module cap_ram #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 10,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (rd_en) rd_data <= mem[raddr];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= rd_en;
   end

   // R11: one-cycle read latency
   p_rd_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);
   p_rd_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
   import cap_buf_pkg::*;
#(
   parameter int NUM_SAMPLES = 1024,
   parameter bit USE_SYNC    = 1'b1,
   parameter int ADDR_W      = 10,
   parameter int CNT_W       = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sync,
   input  logic [REG_W-1:0]  delay,
   input  logic              arm_req,
   input  logic              last_rd,
   output logic              we,
   output logic [ADDR_W-1:0] waddr,
   output logic [CNT_W-1:0]  fill_cnt,
   output cap_phase_t        phase,
   output logic              armed
);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_SAMPLES - 1);
   localparam logic [CNT_W-1:0] FULL_IDX = CNT_W'(NUM_SAMPLES);

   cap_phase_t       ph_q, ph_eff, ph_d;
   logic [REG_W-1:0] skip_q, skip_eff, skip_d;
   logic [CNT_W-1:0] idx_q, idx_eff, idx_d;
   logic             armed_q, armed_d;
   logic             use_skip, start, sync_start, free_start;
   cap_phase_t       ph_rst;

   // trigger and reset-phase variant chosen by USE_SYNC
   generate
      if (USE_SYNC) begin : g_sync_mode
         assign ph_rst = PH_IDLE;
      end else begin : g_free_mode
         assign ph_rst = PH_FILL;
      end
   endgenerate

   assign use_skip   = USE_SYNC && (delay != '0);
   assign sync_start = in_sync && (!use_skip ||
                       (armed_q && ph_q != PH_SKIP && ph_q != PH_FILL));
   assign free_start = (ph_q == PH_DONE) && last_rd;
   assign start      = USE_SYNC ? sync_start : free_start;

   always_comb begin
      ph_eff   = ph_q;
      skip_eff = skip_q;
      idx_eff  = idx_q;
      if (start) begin
         ph_eff   = use_skip ? PH_SKIP : PH_FILL;
         skip_eff = use_skip ? delay : '0;
         idx_eff  = '0;
      end
   end

   assign we    = in_valid && (ph_eff == PH_FILL);
   assign waddr = idx_eff[ADDR_W-1:0];

   always_comb begin
      ph_d   = ph_eff;
      skip_d = skip_eff;
      idx_d  = idx_eff;
      if (in_valid) begin
         case (ph_eff)
            PH_SKIP: begin
               skip_d = skip_eff - 1'b1;
               if (skip_eff == REG_W'(1)) ph_d = PH_FILL;
            end
            PH_FILL: begin
               idx_d = idx_eff + 1'b1;
               if (idx_eff == LAST_IDX) ph_d = PH_DONE;
            end
            default: ;
         endcase
      end
      armed_d = start ? 1'b0 : armed_q;
      if (arm_req) armed_d = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q    <= ph_rst;
         skip_q  <= '0;
         idx_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         ph_q    <= ph_d;
         skip_q  <= skip_d;
         idx_q   <= idx_d;
         armed_q <= armed_d;
      end
   end

   assign fill_cnt = idx_q;
   assign phase    = ph_q;
   assign armed    = armed_q;

   // R1: the count never passes the sample count; done means full
   p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= FULL_IDX);
   p_done_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_DONE) |-> (idx_q == FULL_IDX));
   // R4: last skipped valid cycle leads into the fill phase
   p_skip_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_SKIP && in_valid && skip_q == REG_W'(1) && !start)
      |=> (ph_q == PH_FILL && idx_q == '0));
endmodule

// File: rtl/cap_regs.sv
module cap_regs
   import cap_buf_pkg::*;
#(
   parameter int          CNT_W   = 11,
   parameter logic [31:0] VERSION = 32'h0000_0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [REG_AW-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   input  logic              in_valid,
   input  logic              in_sync,
   input  logic              clr_syncs,
   input  logic [CNT_W-1:0]  fill_cnt,
   output logic [REG_W-1:0]  delay,
   output logic              arm_req,
   output logic [REG_W-1:0]  rd_data,
   output logic              rd_valid
);
   logic [REG_W-1:0] syncs_q, valids_q, dly_q, mux;

   assign arm_req = wr_en && (addr == OFS_VALIDS);
   assign delay   = dly_q;

   always_comb begin
      case (addr)
         OFS_SYNCS:   mux = syncs_q;
         OFS_WORDS:   mux = REG_W'(fill_cnt);
         OFS_VALIDS:  mux = valids_q;
         OFS_DELAY:   mux = dly_q;
         OFS_VERSION: mux = VERSION;
         default:     mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         syncs_q  <= '0;
         valids_q <= '0;
         dly_q    <= '0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         syncs_q  <= (clr_syncs ? '0 : syncs_q) + REG_W'(in_sync);
         valids_q <= (in_sync ? '0 : valids_q) + REG_W'(in_valid);
         if (wr_en && addr == OFS_DELAY) dly_q <= wdata;
         rd_valid <= rd_en;
         if (rd_en) rd_data <= mux;
      end
   end

   p_rd_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);
   p_sync_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sync && !clr_syncs) |=> (syncs_q == $past(syncs_q) + 1));
   p_valid_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sync && !in_valid) |=> (valids_q == '0));
   p_delay_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == OFS_DELAY) |=> $stable(dly_q));
endmodule

// File: rtl/stream_capture_buffer.sv
module stream_capture_buffer
   import cap_buf_pkg::*;
#(
   parameter int          DATA_W      = 32,
   parameter int          NUM_SAMPLES = 1024,
   parameter int          ADDR_W      = $clog2(NUM_SAMPLES),
   parameter bit          USE_SYNC    = 1'b1,
   parameter logic [31:0] VERSION     = 32'h0000_0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_valid,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_sync,
   input  logic              ram_rd_en,
   input  logic [ADDR_W-1:0] ram_rd_addr,
   output logic [DATA_W-1:0] ram_rd_data,
   output logic              ram_rd_valid,
   input  logic              reg_wr_en,
   input  logic              reg_rd_en,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wr_data,
   output logic [31:0]       reg_rd_data,
   output logic              reg_rd_valid
);
   localparam int CNT_W = $clog2(NUM_SAMPLES + 1);
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_SAMPLES - 1);

   generate
      if (NUM_SAMPLES < 2) begin : g_bad_count
         $error("NUM_SAMPLES must be at least 2");
      end
      if (ADDR_W != $clog2(NUM_SAMPLES)) begin : g_bad_addr
         $error("ADDR_W must equal clog2(NUM_SAMPLES)");
      end
      if (DATA_W < 1 || DATA_W > 1024) begin : g_bad_width
         $error("DATA_W out of range");
      end
   endgenerate

   logic              ram_we, arm_req, last_rd, armed;
   logic [ADDR_W-1:0] ram_waddr;
   logic [CNT_W-1:0]  fill_cnt;
   logic [REG_W-1:0]  delay;
   cap_phase_t        phase;

   assign last_rd = ram_rd_en && (ram_rd_addr == LAST_ADDR);

   cap_ctrl #(
      .NUM_SAMPLES(NUM_SAMPLES), .USE_SYNC(USE_SYNC),
      .ADDR_W(ADDR_W), .CNT_W(CNT_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_sync(s_sync),
      .delay(delay), .arm_req(arm_req), .last_rd(last_rd),
      .we(ram_we), .waddr(ram_waddr), .fill_cnt(fill_cnt),
      .phase(phase), .armed(armed)
   );

   cap_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(ram_waddr),
      .wdata(s_data), .rd_en(ram_rd_en), .raddr(ram_rd_addr),
      .rd_data(ram_rd_data), .rd_valid(ram_rd_valid)
   );

   cap_regs #(.CNT_W(CNT_W), .VERSION(VERSION)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
      .addr(reg_addr), .wdata(reg_wr_data), .in_valid(s_valid),
      .in_sync(s_sync), .clr_syncs(last_rd), .fill_cnt(fill_cnt),
      .delay(delay), .arm_req(arm_req), .rd_data(reg_rd_data),
      .rd_valid(reg_rd_valid)
   );

   generate
      if (USE_SYNC) begin : g_oneshot_chk
         // R5: completed armed capture stays frozen until re-armed
         p_one_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (phase == PH_DONE && !armed && delay != '0 &&
             !(reg_wr_en && (reg_addr == OFS_VALIDS || reg_addr == OFS_DELAY)))
            |=> !ram_we);
      end else begin : g_hold_chk
         // R2: free-run capture holds while complete and not read out
         p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (phase == PH_DONE && !last_rd) |=> !ram_we);
      end
   endgenerate
endmodule

// File: tb/stream_capture_buffer_bench.sv
`timescale 1ns/1ps
module stream_capture_buffer_bench;
   localparam int DW = 16;
   localparam int NS = 6;
   localparam int AW = 3;
   localparam logic [31:0] VER = 32'h0000_0102;

   // {delay[31:0], valid mask[15:0]}; bit k of mask = valid in cycle k, sync in cycle 0
   localparam logic [47:0] VEC [0:4] = '{
      {32'd0, 16'hFFFF},
      {32'd0, 16'hAAAB},
      {32'd3, 16'hFFFF},
      {32'd2, 16'h5F5F},
      {32'd5, 16'hFFF7}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          s_valid = 0, s_sync = 0;
   logic [DW-1:0] s_data = '0;
   logic          a_ram_en = 0, a_reg_wr = 0, a_reg_rd = 0;
   logic [AW-1:0] a_ram_addr = '0;
   logic [2:0]    a_reg_addr = '0;
   logic [31:0]   a_reg_wdata = '0;
   logic [DW-1:0] a_ram_data;
   logic          a_ram_vld, a_reg_vld;
   logic [31:0]   a_reg_data;
   logic          f_ram_en = 0, f_reg_rd = 0;
   logic [AW-1:0] f_ram_addr = '0;
   logic [2:0]    f_reg_addr = '0;
   logic [DW-1:0] f_ram_data;
   logic          f_ram_vld, f_reg_vld;
   logic [31:0]   f_reg_data;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   stream_capture_buffer #(.DATA_W(DW), .NUM_SAMPLES(NS), .ADDR_W(AW),
      .USE_SYNC(1'b1), .VERSION(VER)) u_stream_capture_buffer (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_sync(s_sync),
      .ram_rd_en(a_ram_en), .ram_rd_addr(a_ram_addr), .ram_rd_data(a_ram_data),
      .ram_rd_valid(a_ram_vld), .reg_wr_en(a_reg_wr), .reg_rd_en(a_reg_rd),
      .reg_addr(a_reg_addr), .reg_wr_data(a_reg_wdata), .reg_rd_data(a_reg_data),
      .reg_rd_valid(a_reg_vld));

   stream_capture_buffer #(.DATA_W(DW), .NUM_SAMPLES(NS), .ADDR_W(AW),
      .USE_SYNC(1'b0), .VERSION(VER)) u_stream_capture_buffer_free (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_sync(s_sync),
      .ram_rd_en(f_ram_en), .ram_rd_addr(f_ram_addr), .ram_rd_data(f_ram_data),
      .ram_rd_valid(f_ram_vld), .reg_wr_en(1'b0), .reg_rd_en(f_reg_rd),
      .reg_addr(f_reg_addr), .reg_wr_data(32'd0), .reg_rd_data(f_reg_data),
      .reg_rd_valid(f_reg_vld));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [DW-1:0] d, input logic sy);
      @(negedge clk);
      s_valid = v; s_data = d; s_sync = sy;
   endtask

   task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      a_reg_wr = 1; a_reg_addr = a; a_reg_wdata = d;
      @(negedge clk);
      a_reg_wr = 0;
   endtask

   task automatic reg_rd(input bit fr, input logic [2:0] a,
                         output logic [31:0] d, output logic v);
      @(negedge clk);
      if (fr) begin f_reg_rd = 1; f_reg_addr = a; end
      else    begin a_reg_rd = 1; a_reg_addr = a; end
      @(negedge clk);
      f_reg_rd = 0; a_reg_rd = 0;
      d = fr ? f_reg_data : a_reg_data;
      v = fr ? f_reg_vld : a_reg_vld;
   endtask

   task automatic ram_rd(input bit fr, input logic [AW-1:0] a,
                         output logic [DW-1:0] d, output logic v);
      @(negedge clk);
      if (fr) begin f_ram_en = 1; f_ram_addr = a; end
      else    begin a_ram_en = 1; a_ram_addr = a; end
      @(negedge clk);
      f_ram_en = 0; a_ram_en = 0;
      d = fr ? f_ram_data : a_ram_data;
      v = fr ? f_ram_vld : a_ram_vld;
   endtask

   initial begin
      logic [31:0] rd, s0;
      logic [DW-1:0] dd;
      logic vv;
      logic [DW-1:0] ex [NS];
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R12 reset state
      check("R12 ram valid", 32'(a_ram_vld), 0);
      check("R12 reg valid", 32'(a_reg_vld), 0);
      for (int o = 0; o < 8; o++) begin
         reg_rd(0, 3'(o), rd, vv);
         if (o == 7) check("R10 version", rd, VER);
         else        check("R12/R10 reset read", rd, 0);
      end
      // R11 strobe: high with data, low on the following cycle
      reg_rd(0, 3'd7, rd, vv);
      check("R11 reg valid strobe", 32'(vv), 1);
      @(negedge clk);
      check("R11 reg valid drops", 32'(a_reg_vld), 0);
      // R10 writes to read-only / reserved offsets are ignored
      reg_wr(3'd0, 32'hDEAD_BEEF);
      reg_wr(3'd5, 32'h1234_5678);
      reg_wr(3'd7, 32'h0BAD_0BAD);
      reg_rd(0, 3'd0, rd, vv); check("R10 ro syncs", rd, 0);
      reg_rd(0, 3'd5, rd, vv); check("R10 reserved", rd, 0);
      reg_rd(0, 3'd7, rd, vv); check("R10 ro version", rd, VER);
      reg_wr(3'd3, 32'd9);
      reg_rd(0, 3'd3, rd, vv); check("R10 delay rw", rd, 9);

      // table walk: R1, R3, R4, R8, R11
      for (int e = 0; e < 5; e++) begin
         logic [31:0] dl;
         logic [15:0] mk;
         int skip, cap;
         dl = VEC[e][47:16];
         mk = VEC[e][15:0];
         reg_wr(3'd3, dl);
         if (dl != 0) reg_wr(3'd2, 32'd0);
         skip = int'(dl); cap = 0;
         for (int k = 0; k < 16; k++) begin
            if (mk[k]) begin
               if (skip > 0) skip--;
               else if (cap < NS) begin ex[cap] = 16'(16'hA000 + e * 32 + k); cap++; end
            end
         end
         for (int k = 0; k < 16; k++)
            drive(mk[k], 16'(16'hA000 + e * 32 + k), k == 0);
         drive(0, '0, 0);
         for (int i = 0; i < NS; i++) begin
            ram_rd(0, 3'(i), dd, vv);
            check(dl == 0 ? "R3 sync capture" : "R4 armed capture", 32'(dd), 32'(ex[i]));
            check("R11 ram valid", 32'(vv), 1);
         end
         reg_rd(0, 3'd1, rd, vv);
         check("R1/R8 word count full", rd, NS);
      end

      // R5: no re-arm, further syncs write nothing
      for (int k = 0; k < 10; k++) drive(1, 16'(16'hB000 + k), k == 0 || k == 7);
      drive(0, '0, 0);
      for (int i = 0; i < NS; i++) begin
         ram_rd(0, 3'(i), dd, vv);
         check("R5 one-shot hold", 32'(dd), 32'(ex[i]));
      end

      // R6: second sync inside countdown is not a trigger, but is counted
      reg_wr(3'd3, 32'd4);
      reg_wr(3'd2, 32'd0);
      reg_rd(0, 3'd0, s0, vv);
      for (int k = 0; k < 13; k++) drive(1, 16'(16'hC000 + k), k == 0 || k == 2);
      drive(0, '0, 0);
      reg_rd(0, 3'd0, rd, vv);
      check("R6/R7 syncs counted", rd, s0 + 2);
      for (int i = 0; i < NS; i++) begin
         ram_rd(0, 3'(i), dd, vv);
         check("R6 no retrigger", 32'(dd), 32'(16'hC004 + i));
      end

      // R9: valid cycles since sync (not armed, nothing captured)
      drive(0, '0, 1);
      for (int k = 0; k < 3; k++) drive(1, 16'(k), 0);
      drive(0, '0, 0);
      drive(0, '0, 0);
      reg_rd(0, 3'd2, rd, vv);
      check("R9 valid count", rd, 3);

      // R7: clear only on last-address read
      ram_rd(0, 3'd4, dd, vv);
      reg_rd(0, 3'd0, rd, vv);
      check("R7 no clear on addr 4", rd, 1);
      ram_rd(0, 3'(NS - 1), dd, vv);
      reg_rd(0, 3'd0, rd, vv);
      check("R7 clear on last read", rd, 0);

      // R8/R1: new sync capture restarts count, invalid cycles add nothing
      reg_wr(3'd3, 32'd0);
      drive(1, 16'hF000, 1);
      for (int k = 0; k < 3; k++) drive(0, 16'(16'hF100 + k), 0);
      drive(0, '0, 0);
      reg_rd(0, 3'd1, rd, vv);
      check("R8/R1 word count restart", rd, 1);
      ram_rd(0, 3'd0, dd, vv);
      check("R3 sync cycle word", 32'(dd), 32'h0000_F000);

      // R2: free-run instance holds the first samples after reset
      for (int i = 0; i < NS - 1; i++) begin
         ram_rd(1, 3'(i), dd, vv);
         check("R2 first capture", 32'(dd), 32'(16'hA000 + i));
      end
      reg_rd(1, 3'd1, rd, vv);
      check("R2/R8 free word count", rd, NS);
      for (int k = 0; k < 3; k++) drive(1, 16'(16'hD000 + k), 0);
      drive(0, '0, 0);
      ram_rd(1, 3'd0, dd, vv);
      check("R2 held while complete", 32'(dd), 32'h0000_A000);
      ram_rd(1, 3'(NS - 1), dd, vv);
      check("R2 last word", 32'(dd), 32'(16'hA000 + NS - 1));
      reg_rd(1, 3'd1, rd, vv);
      check("R2/R8 restart clears count", rd, 0);
      for (int k = 0; k < 8; k++) drive(k != 2, 16'(16'hE000 + k), 0);
      drive(0, '0, 0);
      for (int i = 0; i < NS; i++) begin
         ram_rd(1, 3'(i), dd, vv);
         check("R2 refill", 32'(dd), 32'(16'hE000 + (i < 2 ? i : i + 1)));
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule